// File: doc/BRIEF.md
# Probeable Memory Window Base Register

This block is the base address register for a single memory window of a bus device. Host software reaches it through a small configuration port: a register select, a write strobe, write data and combinational read data. The window size is fixed at build time as a power of two. Software finds that size by writing all ones to the low register and reading it back. Only the bits at or above the size stay set, so the position of the lowest set bit gives the size.

Software then writes a naturally aligned base. From that point the decode output asserts for every bus address inside the window, as long as the memory-enable input is high. A parameter selects a 32-bit form, which holds one register and decodes 32-bit addresses. The same parameter can instead select a 64-bit form, which adds an upper register so the window can sit above the 4 GB boundary and decodes 64-bit addresses.

Top module: `mem_window_bar`

## Requirements
- R1: After reset the low register reads as its attribute bits with all base bits zero. `hit` stays low for every address, even with `mem_en` high, until the first write to the low register (`cfg_reg` = 0).
- R2: A write of 32'hFFFF_FFFF to the low register makes that register read back with bits [31:SIZE_LOG2] set to one, bits [SIZE_LOG2-1:4] set to zero, and the attribute bits in [3:0].
- R3: A write to the low register keeps only the data bits at or above SIZE_LOG2, so the stored base is always aligned to the window size. SIZE_LOG2 may range from 4 (16 bytes) to 31 (2 GB).
- R4: The low register's bits [3:0] are read-only and read as follows: bit 0 = 0 (memory space); bits [2:1] = 2'b00 in the 32-bit form and 2'b10 in the 64-bit form; bit 3 = PREFETCH. Writes do not change them.
- R5: In the 64-bit form (IS_64 = 1), register select 1 is the upper dword of the base. Every one of its 32 bits is writable and reads back exactly, and the decode compares address bits [63:32] against it. In the 32-bit form, select 1 reads as zero and writes to it are ignored.
- R6: `hit` is high exactly when the block is armed by a low-register write, `mem_en` is high, and the address with its bits below SIZE_LOG2 cleared equals the stored base. The window therefore covers base through base + 2^SIZE_LOG2 - 1.
- R7: While `mem_en` is low, `hit` is low whatever the address and the base.
- R8: `hit` follows `bus_addr` in the same cycle with no register on the way. A register write changes reads and decode from the clock edge that takes it, not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_reg | input | 1 | Register select: 0 low dword, 1 upper dword |
| cfg_we | input | 1 | Write strobe for the selected register |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read data of the selected register (combinational) |
| mem_en | input | 1 | Memory decode enable from the command register |
| bus_addr | input | ADDR_W (32 or 64) | Bus address under decode |
| hit | output | 1 | Address falls inside the programmed window |

## Verification
The hardest cases to reach from the ports are the two extreme edges of the window. One is a 2 GB window whose top edge lands exactly on the 4 GB wrap. The other is a window above 4 GB whose neighbours differ only in the upper dword. Three instances are built, sized 16 bytes, 4 KB (64-bit, above 4 GB) and 2 GB. Each goes through the same sequence: probe readback, an unaligned base write, hit and miss at base - 1, base, base + size - 1 and base + size, and a reprogram during which the old and new bases are both watched on the edge that takes the write.

// File: rtl/bar_pkg.sv
// Package: shared helpers for the memory window base register.
// Assumes window sizes are powers of two given as a log2 value.
package bar_pkg;
    localparam int DWORD_W = 32;

    // Read-only attribute nibble: bit0 memory space, bits2:1 type, bit3 prefetch.
    function automatic logic [3:0] attr_nibble(input bit is64, input bit pf);
        return {pf, is64, 1'b0, 1'b0};
    endfunction

    // Mask with ones at and above the window size bit.
    function automatic logic [63:0] size_mask(input int log2);
        return ~((64'd1 << log2) - 64'd1);
    endfunction
endpackage

// File: rtl/bar_base_lo.sv
// Low dword of the base register. Holds base bits [31:4] above the window
// size, arms decode on its first write, and forms the low read word.
// Assumes 4 <= SIZE_LOG2 <= 31.
module bar_base_lo
    import bar_pkg::*;
#(
    parameter int SIZE_LOG2 = 12,
    parameter bit IS_64     = 1'b0,
    parameter bit PREFETCH  = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [DWORD_W-1:0]   wdata,
    output logic [DWORD_W-1:0]   base_lo,
    output logic                 armed,
    output logic [DWORD_W-1:0]   rd_word
);
    localparam logic [63:0]        FULL_MASK = size_mask(SIZE_LOG2);
    localparam logic [DWORD_W-1:0] WR_MASK   = FULL_MASK[DWORD_W-1:0] & 32'hFFFF_FFF0;
    localparam logic [3:0]         ATTR      = attr_nibble(IS_64, PREFETCH);

    logic [DWORD_W-1:0] base_q;
    logic               armed_q;

    // Capture writable base bits and arm the window on any low write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            armed_q <= 1'b0;
        end else if (wr_en) begin
            base_q  <= wdata & WR_MASK;
            armed_q <= 1'b1;
        end
    end

    assign base_lo = base_q;
    assign armed   = armed_q;
    assign rd_word = base_q | {{(DWORD_W-4){1'b0}}, ATTR};
endmodule

// File: rtl/bar_base_hi.sv
// Upper dword of a 64-bit base register. Every bit is writable.
// Assumes it is instantiated only in the 64-bit form.
module bar_base_hi
    import bar_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [DWORD_W-1:0] wdata,
    output logic [DWORD_W-1:0] base_hi
);
    logic [DWORD_W-1:0] hi_q;

    // Replace the whole upper dword on each write.
    always_ff @(posedge clk) begin
        if (!rst_n)     hi_q <= '0;
        else if (wr_en) hi_q <= wdata;
    end

    assign base_hi = hi_q;
endmodule

// File: rtl/bar_window_decode.sv
// Address decoder: compares the address, cleared below the window size,
// with the stored base. Assumes the base has no bits below SIZE_LOG2.
module bar_window_decode
    import bar_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int SIZE_LOG2 = 12
) (
    input  logic [ADDR_W-1:0] base,
    input  logic              armed,
    input  logic              mem_en,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam logic [63:0]       FULL_MASK = size_mask(SIZE_LOG2);
    localparam logic [ADDR_W-1:0] ADDR_MASK = FULL_MASK[ADDR_W-1:0];

    // Combinational window match gated by enable and arming.
    always_comb begin
        hit = mem_en && armed && ((addr & ADDR_MASK) == base);
    end
endmodule

// File: rtl/mem_window_bar.sv
// Top: probeable base address register for one memory window, 32-bit or
// 64-bit form. Config reads are combinational. Decode has no latency.
// Assumes 4 <= SIZE_LOG2 <= 31 and one register select bit.
module mem_window_bar
    import bar_pkg::*;
#(
    parameter int SIZE_LOG2 = 12,
    parameter bit IS_64     = 1'b0,
    parameter bit PREFETCH  = 1'b0,
    localparam int ADDR_W   = IS_64 ? 64 : 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_reg,
    input  logic               cfg_we,
    input  logic [31:0]        cfg_wdata,
    output logic [31:0]        cfg_rdata,
    input  logic               mem_en,
    input  logic [ADDR_W-1:0]  bus_addr,
    output logic               hit
);
    localparam logic [63:0] PROBE_FULL = size_mask(SIZE_LOG2);

    logic               wr_lo, wr_hi, armed;
    logic [31:0]        lo_base, lo_word, hi_word;
    logic [ADDR_W-1:0]  base_full;

    assign wr_lo = cfg_we && !cfg_reg;
    assign wr_hi = cfg_we &&  cfg_reg;

    bar_base_lo #(
        .SIZE_LOG2 (SIZE_LOG2),
        .IS_64     (IS_64),
        .PREFETCH  (PREFETCH)
    ) u_lo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_lo),
        .wdata   (cfg_wdata),
        .base_lo (lo_base),
        .armed   (armed),
        .rd_word (lo_word)
    );

    if (IS_64) begin : g_wide
        bar_base_hi u_hi (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_hi),
            .wdata   (cfg_wdata),
            .base_hi (hi_word)
        );
        assign base_full = {hi_word, lo_base};

        // R5: the upper dword reads back exactly what was written.
        a_r5_hi_exact: assert property (@(posedge clk) disable iff (!rst_n)
            wr_hi |=> (hi_word == $past(cfg_wdata)));
    end else begin : g_narrow
        assign hi_word   = '0;
        assign base_full = lo_base;
    end

    // Select the read word of the addressed register.
    always_comb begin
        cfg_rdata = cfg_reg ? hi_word : lo_word;
    end

    bar_window_decode #(
        .ADDR_W    (ADDR_W),
        .SIZE_LOG2 (SIZE_LOG2)
    ) u_dec (
        .base   (base_full),
        .armed  (armed),
        .mem_en (mem_en),
        .addr   (bus_addr),
        .hit    (hit)
    );

    // R1: no decode in the cycle that follows reset.
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !hit);

    // R2: an all-ones probe reads back as the size mask.
    a_r2_probe_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && cfg_wdata == 32'hFFFF_FFFF) |=>
        (lo_word[31:4] == PROBE_FULL[31:4]));

    // R4: writes leave the attribute nibble untouched.
    a_r4_attr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (lo_word[3:0] == $past(lo_word[3:0])));

    // R7: decode disabled means no hit.
    a_r7_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_en |-> !hit);
endmodule

// File: tb/tb_mem_window_bar.sv
module tb_mem_window_bar;
    localparam int CLK_PERIOD = 10;
    localparam int NCFG = 3;
    localparam int SZS [NCFG] = '{4, 12, 31};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done [NCFG];

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic void check(input string tag, input logic [63:0] act,
                                  input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endfunction

    for (genvar g = 0; g < NCFG; g++) begin : g_cfg
        localparam int          S     = SZS[g];
        localparam bit          IS    = (g == 1);
        localparam bit          PF    = (g != 0);
        localparam int          AW    = IS ? 64 : 32;
        localparam logic [63:0] MSK64 = ~((64'd1 << S) - 64'd1);
        localparam logic [31:0] M32   = MSK64[31:0] & 32'hFFFF_FFF0;
        localparam logic [63:0] AMSK  = IS ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
        localparam logic [31:0] ATTR  = {28'd0, PF, IS, 2'b00};
        localparam logic [63:0] SIZE  = 64'd1 << S;
        localparam logic [31:0] B_LO  = (g == 0) ? 32'h1234_5670 :
                                        (g == 1) ? 32'hFEDC_B000 : 32'h8000_0000;
        localparam logic [31:0] B_HI  = IS ? 32'h0000_0001 : 32'h0;
        localparam logic [63:0] BASE  = {B_HI, B_LO};
        localparam logic [31:0] B2_LO = B_LO ^ SIZE[31:0];
        localparam logic [63:0] BASE2 = {B_HI, B2_LO};

        logic        cfg_reg, cfg_we, mem_en, hit;
        logic [31:0] cfg_wdata, rdata;
        logic [63:0] addr;

        mem_window_bar #(.SIZE_LOG2(S), .IS_64(IS), .PREFETCH(PF)) dut (
            .clk(clk), .rst_n(rst_n), .cfg_reg(cfg_reg), .cfg_we(cfg_we),
            .cfg_wdata(cfg_wdata), .cfg_rdata(rdata), .mem_en(mem_en),
            .bus_addr(addr[AW-1:0]), .hit(hit));

        // Behavioural reference model, compared on every falling edge.
        logic [63:0] m_base;
        bit          m_armed;
        bit          live = 1'b0;

        always @(posedge clk) begin
            if (!rst_n) begin
                m_base = 64'd0; m_armed = 1'b0; live = 1'b1;
            end else if (cfg_we) begin
                if (!cfg_reg) begin
                    m_base[31:0] = cfg_wdata & M32; m_armed = 1'b1;
                end else if (IS) begin
                    m_base[63:32] = cfg_wdata;
                end
            end
        end

        always @(negedge clk) begin
            if (live) begin
                logic [31:0] e_rd;
                logic        e_hit;
                e_rd  = cfg_reg ? (IS ? m_base[63:32] : 32'd0) : (m_base[31:0] | ATTR);
                e_hit = mem_en && m_armed && (((addr & AMSK) & MSK64) == m_base);
                check($sformatf("R5 model read cfg%0d", g), {32'd0, rdata}, {32'd0, e_rd});
                check($sformatf("R6 model hit cfg%0d", g), {63'd0, hit}, {63'd0, e_hit});
            end
        end

        task automatic drive(input bit r, input bit we, input logic [31:0] wd,
                             input bit en, input logic [63:0] a);
            @(posedge clk); #1;
            cfg_reg = r; cfg_we = we; cfg_wdata = wd; mem_en = en; addr = a;
        endtask

        task automatic see_rd(input string tag, input logic [31:0] exp);
            @(negedge clk);
            check($sformatf("%s cfg%0d", tag, g), {32'd0, rdata}, {32'd0, exp});
        endtask

        task automatic see_hit(input string tag, input bit exp);
            @(negedge clk);
            check($sformatf("%s cfg%0d", tag, g), {63'd0, hit}, {63'd0, exp});
        endtask

        initial begin
            cfg_reg = 0; cfg_we = 0; cfg_wdata = 0; mem_en = 0; addr = 0;
            @(posedge rst_n);
            // R1: reset state, unarmed decode with address that matches a zero base
            drive(0, 0, 32'd0, 1, 64'd0);
            see_rd("R1 reset read", ATTR);
            drive(0, 0, 32'd0, 1, 64'd0);
            see_hit("R1 unarmed no hit", 1'b0);
            // R2: all-ones probe
            drive(0, 1, 32'hFFFF_FFFF, 0, 64'd0);
            drive(0, 0, 32'd0, 0, 64'd0);
            see_rd("R2 probe readback", M32 | ATTR);
            // R5: upper dword probe
            drive(1, 1, 32'hFFFF_FFFF, 0, 64'd0);
            drive(1, 0, 32'd0, 0, 64'd0);
            see_rd("R5 upper dword", IS ? 32'hFFFF_FFFF : 32'd0);
            // R3 and R4: unaligned base write with low bits set
            drive(0, 1, B_LO | ((SIZE[31:0] - 32'd1) | 32'hF), 0, 64'd0);
            drive(0, 0, 32'd0, 0, 64'd0);
            see_rd("R3 aligned base R4 attr", B_LO | ATTR);
            drive(1, 1, B_HI, 0, 64'd0);
            drive(1, 0, 32'd0, 0, 64'd0);
            see_rd("R5 upper base", B_HI);
            // R6: window edges
            drive(0, 0, 32'd0, 1, BASE);
            see_hit("R6 base hit", 1'b1);
            drive(0, 0, 32'd0, 1, BASE + SIZE - 64'd1);
            see_hit("R6 top hit", 1'b1);
            drive(0, 0, 32'd0, 1, BASE - 64'd1);
            see_hit("R6 below miss", 1'b0);
            drive(0, 0, 32'd0, 1, BASE + SIZE);
            see_hit("R6 above miss", 1'b0);
            // R7: enable gate
            drive(0, 0, 32'd0, 0, BASE);
            see_hit("R7 disabled miss", 1'b0);
            // R5: upper address bits take part in decode
            if (IS) begin
                drive(0, 0, 32'd0, 1, BASE ^ (64'd1 << 40));
                see_hit("R5 upper mismatch miss", 1'b0);
            end
            // R8: reprogram, old base in force until the edge
            drive(0, 1, B2_LO, 1, BASE2);
            see_hit("R8 before edge miss", 1'b0);
            drive(0, 0, 32'd0, 1, BASE2);
            see_hit("R8 after edge hit", 1'b1);
            drive(0, 0, 32'd0, 1, BASE);
            see_hit("R8 old base miss", 1'b0);
            drive(0, 0, 32'd0, 0, 64'd0);
            done[g] = 1'b1;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done[0] && done[1] && done[2]);
                @(negedge clk);
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog expired actual=hung expected=done");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule